// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block deserialises a two-channel audio stream made of a bit clock, a word-select line and a serial data line. It runs directly on the bit clock. It sends out a left/right pair of 24-bit two's-complement samples with a single-cycle valid strobe once per frame. A two-bit format input selects how each word sits inside its half-frame:

- right-justified 16-bit
- left-justified 24-bit
- right-justified 24-bit
- I2S, which carries 16-bit or 24-bit words depending on the half-frame length

The block counts the bit clocks in every half-frame and keeps a history of the bits shifted in. This lets it take the word when word select toggles, wherever the word starts. As a result, the right-justified formats work at any bit-clock rate from the minimum up to the history depth. Words of 16 bits are returned in the upper 16 bits of the sample, with the low byte cleared. After a reset or a format change, the block waits for the start of a left-channel half-frame before it accepts data.

Top module: `audio_serial_rx`

## Requirements
- R1: While `rst` is high on a clock edge, the block clears `valid_o`, `left_o` and `right_o` to zero.
- R2: With `fmt_i` = 2'b00 (right-justified 16-bit, word select high = left), the word is the last 16 bits before the word-select toggle. It is output as {word, 8'h00}. A half-frame must be at least 16 bit clocks long.
- R3: With `fmt_i` = 2'b10 (right-justified 24-bit, word select high = left), the word is the last 24 bits before the word-select toggle. A half-frame must be at least 24 bit clocks long.
- R4: With `fmt_i` = 2'b01 (left-justified 24-bit, word select high = left), the MSB is the bit sampled on the first rising edge that sees the new word-select level. The next 23 bits follow MSB first.
- R5: With `fmt_i` = 2'b11 (I2S, word select low = left) and a half-frame of 24 or more bit clocks, the 24-bit word starts one bit clock after the toggle. Its LSB may fall on the first bit of the following half-frame.
- R6: With `fmt_i` = 2'b11 and a half-frame of exactly 16 bit clocks, the word is 16 bits long. It starts one bit clock after the toggle and is output as {word, 8'h00}.
- R7: `valid_o` is high for exactly one cycle: the cycle after the edge that ends a right half-frame whose matching left half-frame was accepted. `left_o` and `right_o` update in that same cycle and hold at all other times.
- R8: Data is accepted only for a half-frame that began at a toggle into the left channel, or that follows one. A partial frame after reset produces no output.
- R9: A change on `fmt_i` discards any pending data. No output is produced until the next full left then right pair under the new format.
- R10: A half-frame shorter than the format's minimum is discarded. A half-frame longer than `MAX_HALF` bit clocks is also discarded. Its frame produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; everything samples on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ws_i | input | 1 | Word select (channel marker) |
| sd_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 2 | Framing select (00, 01, 10, 11 as in R2 to R6) |
| left_o | output | 24 | Left sample, two's complement |
| right_o | output | 24 | Right sample, two's complement |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |

## Verification
The assertions check on every cycle that the strobe lasts one cycle and follows a word-select toggle, that the outputs hold between strobes, and that a format change is never followed directly by a strobe. Only the bench scenarios can show that the correct bits are taken from each framing:

- the bit-clock counts of 16, 24, 32 and 48 per half
- the I2S LSB spilling into the next half-frame
- the rejection of short halves and partial frames

// File: rtl/asr_pkg.sv
package asr_pkg;

    localparam int SAMPLE_W = 24;
    localparam int SHORT_W  = 16;

    typedef enum logic [1:0] {
        FMT_RJ16 = 2'b00,
        FMT_LJ24 = 2'b01,
        FMT_RJ24 = 2'b10,
        FMT_I2S  = 2'b11
    } fmt_e;

    typedef struct packed {
        logic                ok;
        logic [SAMPLE_W-1:0] word;
    } pick_t;

    // Word-select level that marks the left channel in a given framing.
    function automatic logic left_level(fmt_e f);
        return (f != FMT_I2S);
    endfunction

    // Place a short word in the upper bits of a full sample.
    function automatic logic [SAMPLE_W-1:0] widen_short(logic [SHORT_W-1:0] w);
        return {w, {(SAMPLE_W-SHORT_W){1'b0}}};
    endfunction

endpackage

// File: rtl/asr_frame_track.sv
module asr_frame_track
    import asr_pkg::*;
#(
    parameter int MAX_HALF = 64,
    parameter int CNT_W    = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ws_i,
    input  logic                sd_i,
    input  fmt_e                fmt_i,
    output logic                flip_o,
    output logic [CNT_W-1:0]    len_o,
    output logic [MAX_HALF-1:0] hist_o,
    output logic                ended_left_o,
    output logic                synced_o,
    output fmt_e                fmt_o,
    output logic                fmt_chg_o
);

    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_HALF + 1);

    logic                ws_q;
    logic                primed_q;
    logic                sync_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [MAX_HALF-1:0] hist_q;
    fmt_e                fmt_q;

    assign flip_o       = primed_q && (ws_i != ws_q);
    assign fmt_chg_o    = (fmt_i != fmt_q);
    assign len_o        = cnt_q;
    assign hist_o       = hist_q;
    assign ended_left_o = (ws_q == left_level(fmt_q));
    assign synced_o     = sync_q;
    assign fmt_o        = fmt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ws_q     <= 1'b0;
            primed_q <= 1'b0;
            sync_q   <= 1'b0;
            cnt_q    <= '0;
            hist_q   <= '0;
            fmt_q    <= fmt_i;
        end else begin
            ws_q     <= ws_i;
            primed_q <= 1'b1;
            fmt_q    <= fmt_i;
            hist_q   <= {hist_q[MAX_HALF-2:0], sd_i};
            if (flip_o)
                cnt_q <= CNT_W'(1);
            else if (cnt_q != CNT_SAT)
                cnt_q <= cnt_q + 1'b1;
            if (fmt_chg_o)
                sync_q <= 1'b0;
            else if (flip_o && (ws_i == left_level(fmt_q)))
                sync_q <= 1'b1;
        end
    end

endmodule

// File: rtl/asr_word_pick.sv
module asr_word_pick
    import asr_pkg::*;
#(
    parameter int MAX_HALF = 64,
    parameter int CNT_W    = 7
) (
    input  fmt_e                fmt_i,
    input  logic [MAX_HALF-1:0] hist_i,
    input  logic                sd_i,
    input  logic [CNT_W-1:0]    len_i,
    output pick_t               pick_o
);

    localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(SHORT_W);
    localparam logic [CNT_W-1:0] LEN_FULL  = CNT_W'(SAMPLE_W);
    localparam logic [CNT_W-1:0] LEN_MAX   = CNT_W'(MAX_HALF);

    logic [MAX_HALF:0]   ext;
    logic [MAX_HALF:0]   ext_sh;
    logic [MAX_HALF-1:0] hist_sh;
    pick_t               res;

    assign ext = {hist_i, sd_i};

    always_comb begin
        res     = '0;
        hist_sh = hist_i >> (len_i - LEN_FULL);
        ext_sh  = ext >> (len_i - LEN_FULL);
        case (fmt_i)
            FMT_RJ16: begin
                res.ok   = (len_i >= LEN_SHORT);
                res.word = widen_short(hist_i[SHORT_W-1:0]);
            end
            FMT_RJ24: begin
                res.ok   = (len_i >= LEN_FULL);
                res.word = hist_i[SAMPLE_W-1:0];
            end
            FMT_LJ24: begin
                res.ok   = (len_i >= LEN_FULL);
                res.word = hist_sh[SAMPLE_W-1:0];
            end
            default: begin
                if (len_i == LEN_SHORT) begin
                    res.ok   = 1'b1;
                    res.word = widen_short(ext[SHORT_W-1:0]);
                end else begin
                    res.ok   = (len_i >= LEN_FULL);
                    res.word = ext_sh[SAMPLE_W-1:0];
                end
            end
        endcase
        if (len_i > LEN_MAX)
            res.ok = 1'b0;
    end

    assign pick_o = res;

endmodule

// File: rtl/asr_pair_out.sv
module asr_pair_out
    import asr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                flip_i,
    input  logic                synced_i,
    input  logic                fmt_chg_i,
    input  logic                ended_left_i,
    input  pick_t               pick_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);

    logic                take;
    logic                have_left_q;
    logic [SAMPLE_W-1:0] pend_q;

    assign take = flip_i && synced_i && !fmt_chg_i && pick_i.ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_left_q <= 1'b0;
            pend_q      <= '0;
            left_o      <= '0;
            right_o     <= '0;
            valid_o     <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (fmt_chg_i || (flip_i && !take)) begin
                have_left_q <= 1'b0;
            end else if (take) begin
                if (ended_left_i) begin
                    pend_q      <= pick_i.word;
                    have_left_q <= 1'b1;
                end else begin
                    have_left_q <= 1'b0;
                    if (have_left_q) begin
                        left_o  <= pend_q;
                        right_o <= pick_i.word;
                        valid_o <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
    import asr_pkg::*;
#(
    parameter int MAX_HALF = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ws_i,
    input  logic                sd_i,
    input  logic [1:0]          fmt_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);

    localparam int CNT_W = $clog2(MAX_HALF + 2);

    fmt_e                fmt_sel;
    fmt_e                fmt_reg;
    logic                flip;
    logic [CNT_W-1:0]    half_len;
    logic [MAX_HALF-1:0] hist;
    logic                ended_left;
    logic                synced;
    logic                fmt_chg;
    pick_t               pick;

    assign fmt_sel = fmt_e'(fmt_i);

    asr_frame_track #(.MAX_HALF(MAX_HALF), .CNT_W(CNT_W)) track_i (
        .clk          (clk),
        .rst          (rst),
        .ws_i         (ws_i),
        .sd_i         (sd_i),
        .fmt_i        (fmt_sel),
        .flip_o       (flip),
        .len_o        (half_len),
        .hist_o       (hist),
        .ended_left_o (ended_left),
        .synced_o     (synced),
        .fmt_o        (fmt_reg),
        .fmt_chg_o    (fmt_chg)
    );

    asr_word_pick #(.MAX_HALF(MAX_HALF), .CNT_W(CNT_W)) pick_i (
        .fmt_i  (fmt_reg),
        .hist_i (hist),
        .sd_i   (sd_i),
        .len_i  (half_len),
        .pick_o (pick)
    );

    asr_pair_out pair_i (
        .clk          (clk),
        .rst          (rst),
        .flip_i       (flip),
        .synced_i     (synced),
        .fmt_chg_i    (fmt_chg),
        .ended_left_i (ended_left),
        .pick_i       (pick),
        .left_o       (left_o),
        .right_o      (right_o),
        .valid_o      (valid_o)
    );

endmodule

// File: rtl/audio_serial_rx_chk.sv
module audio_serial_rx_chk (
    input logic        clk,
    input logic        rst,
    input logic        ws_i,
    input logic [1:0]  fmt_i,
    input logic [23:0] left_o,
    input logic [23:0] right_o,
    input logic        valid_o
);

    // R7: the strobe never lasts longer than one cycle
    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R7: the sample outputs move only together with the strobe
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ($stable(left_o) && $stable(right_o)));

    // R7: a strobe follows the cycle in which word select toggled
    p_after_flip_r7: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> ($past(ws_i, 1) != $past(ws_i, 2)));

    // R9: a framing change is never followed directly by a strobe
    p_fmt_change_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (fmt_i != $past(fmt_i)) |=> !valid_o);

endmodule

bind audio_serial_rx audio_serial_rx_chk chk_i (.*);

// File: tb/audio_serial_rx_tb_top.sv
module audio_serial_rx_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst;
    logic        ws_i;
    logic        sd_i;
    logic [1:0]  fmt_i;
    logic [23:0] left_o;
    logic [23:0] right_o;
    logic        valid_o;

    audio_serial_rx dut_i (
        .clk     (clk),
        .rst     (rst),
        .ws_i    (ws_i),
        .sd_i    (sd_i),
        .fmt_i   (fmt_i),
        .left_o  (left_o),
        .right_o (right_o),
        .valid_o (valid_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails = 0;
    int mon_checks = 0;
    int mon_fails = 0;

    logic [1:0]  cur_fmt = 2'b01;
    logic        spill_v = 1'b0;
    logic        spill_b = 1'b0;
    string       phase_tag = "R1";

    logic [23:0] exp_l_q[$];
    logic [23:0] exp_r_q[$];
    string       exp_tag_q[$];

    logic [23:0] last_l = '0;
    logic [23:0] last_r = '0;
    logic        chk_next = 1'b0;

    function automatic logic lvl_left(logic [1:0] f);
        return (f != 2'b11);
    endfunction

    function automatic logic [23:0] exp_word(logic [1:0] f, int n, logic [23:0] w);
        if (f == 2'b00 || (f == 2'b11 && n == 16))
            return {w[23:8], 8'h00};
        return w;
    endfunction

    function automatic int pick_len(logic [1:0] f);
        int sel;
        sel = int'($urandom_range(0, 2));
        if (f == 2'b01 || f == 2'b10)
            return (sel == 0) ? 24 : (sel == 1) ? 32 : 48;
        return (sel == 0) ? 16 : (sel == 1) ? 24 : 32;
    endfunction

    task automatic drive(input logic lvl, input logic b);
        @(negedge clk);
        ws_i  = lvl;
        sd_i  = b;
        fmt_i = cur_fmt;
    endtask

    task automatic send_half(input logic [1:0] f, input logic lvl, input int n, input logic [23:0] w);
        int wl;
        wl = (n == 16) ? 16 : 24;
        for (int p = 0; p < n; p++) begin
            logic b;
            b = 1'($urandom_range(0, 1));
            if (p == 0 && spill_v) b = spill_b;
            case (f)
                2'b00: if (p >= n - 16) b = w[23 - (p - (n - 16))];
                2'b10: if (p >= n - 24) b = w[23 - (p - (n - 24))];
                2'b01: if (p < 24) b = w[23 - p];
                default: if (p >= 1 && p <= wl) b = w[24 - p];
            endcase
            drive(lvl, b);
        end
        spill_v = (f == 2'b11) && (wl == n);
        spill_b = w[24 - wl];
    endtask

    task automatic send_frame(input int n, input logic [23:0] l, input logic [23:0] r,
                              input logic expect_out, input string tag);
        if (expect_out) begin
            exp_l_q.push_back(exp_word(cur_fmt, n, l));
            exp_r_q.push_back(exp_word(cur_fmt, n, r));
            exp_tag_q.push_back(tag);
        end
        send_half(cur_fmt, lvl_left(cur_fmt), n, l);
        send_half(cur_fmt, !lvl_left(cur_fmt), n, r);
    endtask

    task automatic flush();
        send_half(cur_fmt, lvl_left(cur_fmt), 32, $urandom());
    endtask

    task automatic start_mode(input logic [1:0] f);
        if (f != cur_fmt) begin
            flush();
            cur_fmt = f;
            send_half(f, !lvl_left(f), 32, $urandom());
        end
    endtask

    task automatic check_reset_state(input string tag);
        checks++;
        if (valid_o !== 1'b0 || left_o !== 24'h0 || right_o !== 24'h0) begin
            fails++;
            $display("FAIL %s reset state: valid=%0b left=%h right=%h expected 0/000000/000000",
                     tag, valid_o, left_o, right_o);
        end
    endtask

    task automatic do_reset(input logic ws_level);
        @(negedge clk);
        rst = 1'b1;
        ws_i = ws_level;
        sd_i = 1'b0;
        fmt_i = cur_fmt;
        spill_v = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        last_l = '0;
        last_r = '0;
        check_reset_state("R1");
    endtask

    // Output monitor: compares each strobe with the queue of expected pairs
    always @(negedge clk) begin
        if (!rst) begin
            if (chk_next) begin
                mon_checks++;
                if (valid_o || left_o != last_l || right_o != last_r) begin
                    mon_fails++;
                    $display("FAIL R7 hold after strobe: valid=%0b left=%h right=%h expected 0/%h/%h",
                             valid_o, left_o, right_o, last_l, last_r);
                end
                chk_next = 1'b0;
            end
            if (valid_o) begin
                mon_checks++;
                if (exp_l_q.size() == 0) begin
                    mon_fails++;
                    $display("FAIL %s unexpected strobe: left=%h right=%h expected no strobe",
                             phase_tag, left_o, right_o);
                end else begin
                    logic [23:0] el;
                    logic [23:0] er;
                    string       tg;
                    el = exp_l_q.pop_front();
                    er = exp_r_q.pop_front();
                    tg = exp_tag_q.pop_front();
                    if (left_o != el || right_o != er) begin
                        mon_fails++;
                        $display("FAIL %s pair mismatch: left=%h right=%h expected %h/%h",
                                 tg, left_o, right_o, el, er);
                    end
                end
                last_l = left_o;
                last_r = right_o;
                chk_next = 1'b1;
            end
        end
    end

    task automatic report_and_finish();
        checks += mon_checks;
        fails  += mon_fails;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mon_checks++;
        mon_fails++;
        $display("FAIL watchdog: run did not complete, actual timeout expected completion");
        report_and_finish();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        ws_i = 1'b0;
        sd_i = 1'b0;
        fmt_i = 2'b01;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        check_reset_state("R1");

        // R4: left-justified 24-bit
        phase_tag = "R4";
        send_half(cur_fmt, 1'b0, 32, 24'h0);
        send_frame(32, 24'h800001, 24'h7FFFFE, 1'b1, "R4");
        send_frame(24, 24'hA5C33C, 24'h0F0F0F, 1'b1, "R4");
        send_frame(48, 24'h123456, 24'hFEDCBA, 1'b1, "R4");

        // R3: right-justified 24-bit
        start_mode(2'b10);
        phase_tag = "R3";
        send_frame(32, 24'hC00003, 24'h3FFFFC, 1'b1, "R3");
        send_frame(24, 24'h5A5A5A, 24'h000001, 1'b1, "R3");

        // R2: right-justified 16-bit
        start_mode(2'b00);
        phase_tag = "R2";
        send_frame(16, 24'hABCD00, 24'h8001FF, 1'b1, "R2");
        send_frame(32, 24'h7FFF11, 24'h123499, 1'b1, "R2");

        // R5 and R6: I2S framing
        start_mode(2'b11);
        phase_tag = "R5";
        send_frame(32, 24'h900009, 24'h6FFFF6, 1'b1, "R5");
        send_frame(24, 24'h3C3C3D, 24'hC3C3C2, 1'b1, "R5");
        phase_tag = "R6";
        send_frame(16, 24'hF00F00, 24'h0FF1AA, 1'b1, "R6");
        send_frame(16, 24'h800155, 24'h7FFE77, 1'b1, "R6");

        // R10: short half-frames are dropped
        start_mode(2'b01);
        phase_tag = "R10";
        send_half(cur_fmt, 1'b1, 32, 24'h111111);
        send_half(cur_fmt, 1'b0, 20, 24'h222222);
        send_frame(32, 24'h333333, 24'h444444, 1'b1, "R10");
        start_mode(2'b00);
        phase_tag = "R10";
        send_half(cur_fmt, 1'b1, 32, 24'h555555);
        send_half(cur_fmt, 1'b0, 12, 24'h666666);
        send_frame(32, 24'h777700, 24'h888800, 1'b1, "R10");

        // R9: framing change in the middle of a frame
        start_mode(2'b10);
        send_frame(32, 24'h010203, 24'h040506, 1'b1, "R9");
        phase_tag = "R9";
        send_half(cur_fmt, 1'b1, 32, 24'hAAAAAA);
        cur_fmt = 2'b01;
        send_half(cur_fmt, 1'b0, 32, 24'hBBBBBB);
        send_frame(32, 24'hCCCCCC, 24'hDDDDDD, 1'b1, "R9");

        // R8: partial frame after reset
        flush();
        repeat (4) @(negedge clk);
        phase_tag = "R8";
        do_reset(1'b1);
        for (int i = 0; i < 10; i++) drive(1'b1, 1'($urandom_range(0, 1)));
        send_half(cur_fmt, 1'b0, 32, 24'h999999);
        send_frame(32, 24'hE1E2E3, 24'hF1F2F3, 1'b1, "R8");

        // Random frames in every framing
        for (int k = 0; k < 200; k++) begin
            int n;
            if (k % 10 == 0) begin
                start_mode(2'($urandom_range(0, 3)));
            end
            phase_tag = "R7";
            n = pick_len(cur_fmt);
            send_frame(n, $urandom(), $urandom(), 1'b1,
                       (cur_fmt == 2'b00) ? "R2" : (cur_fmt == 2'b01) ? "R4" :
                       (cur_fmt == 2'b10) ? "R3" : (n == 16) ? "R6" : "R5");
        end

        flush();
        repeat (5) @(negedge clk);
        checks++;
        if (exp_l_q.size() != 0) begin
            fails++;
            $display("FAIL R7 missing strobes: %0d pairs outstanding, expected 0", exp_l_q.size());
        end
        report_and_finish();
    end

endmodule